// File: doc/BRIEF.md
# Vector quadword shift-right unit

This unit runs two logical right shifts on a 128-bit vector operand. It takes a 32-bit instruction word, a data operand A and a count operand B. The instruction word selects one of the two operations. One operation moves A by 0 to 7 bit positions. The other moves A by 0 to 15 whole bytes. Data moves toward the least significant end, bits that pass the end are discarded, and zeros enter at the most significant end. Bit 0 of the architectural numbering is the most significant bit, so it is vector index `[127]`.

The shift count is read from fixed low-order fields of B. The bit-granular shift has one more rule: every byte of B must carry the same 3-bit count in its low bits. When any byte breaks that rule, the unit still delivers the shifted value and raises an undefined-result flag. Opcodes the unit does not know give a zero result with the valid flag low. The result can leave through an output register or straight from the logic, as a parameter chooses. Neither operation changes any state apart from that optional output register.

Top module: `vqsr_unit`

## Requirements
- R1: An instruction is recognized only if `instr[31:26]` equals 4 (architectural bits 0:5). Extended opcode `instr[10:0]` = 708 selects the bit shift and 1100 selects the byte shift. A recognized instruction drives `res_valid` high.
- R2: For the bit shift, the result is `opnd_a >> opnd_b[2:0]` (architectural bits 125:127 of B), with zeros filling the high end.
- R3: For the bit shift, `res_undef` is 1 exactly when some byte k (0..15) has `opnd_b[8k+2:8k]` different from `opnd_b[2:0]`. The result is still `opnd_a >> opnd_b[2:0]`.
- R4: For the byte shift, the result is `opnd_a >> (8 * opnd_b[6:3])` (architectural bits 121:124 of B), with zeros filling the high end.
- R5: The byte shift depends on no bit of `opnd_b` outside `[6:3]`, and it keeps `res_undef` at 0.
- R6: For any other primary or extended opcode, `res_valid` is 0, `res_undef` is 0 and `res_data` is zero.
- R7: With `REG_OUT`=1, all three outputs show the inputs of the previous rising clock edge. With `REG_OUT`=0, they follow the current inputs in the same cycle.
- R8: With `REG_OUT`=1, a rising edge with `rst` high clears `res_valid`, `res_undef` and `res_data` to 0.
- R9: The register-number fields `instr[25:11]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| instr | input | 32 | Instruction word; primary opcode in [31:26], extended opcode in [10:0] |
| opnd_a | input | DATA_W | Data operand to be shifted |
| opnd_b | input | DATA_W | Count operand |
| res_data | output | DATA_W | Shifted result, zero when not valid |
| res_valid | output | 1 | A recognized operation produced the result |
| res_undef | output | 1 | Bit-shift count bytes disagree; the result is architecturally undefined |

## Verification
The bench builds two copies of the block side by side and feeds them the same inputs. The first uses the defaults: an output register and the logarithmic stage chain. It exercises the one-cycle alignment of valid and undefined flags with the data, and the synchronous clear. The second has `REG_OUT`=0 with the direct shift operator, so the combinational path and the other shifter variant are compared in the same cycle against one model.

// File: rtl/vqsr_pkg.sv
package vqsr_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned PRI_W   = 6;
   localparam int unsigned REGF_W  = 5;
   localparam int unsigned XO_W    = 11;
   localparam int unsigned LANE_W  = 8;
   localparam int unsigned BIT_W   = 3;

   typedef enum logic [1:0] {
      VQ_OP_NONE  = 2'd0,
      VQ_OP_BITS  = 2'd1,
      VQ_OP_BYTES = 2'd2
   } vq_op_e;

   typedef struct packed {
      logic [PRI_W-1:0]  pri;
      logic [REGF_W-1:0] dst;
      logic [REGF_W-1:0] src_a;
      logic [REGF_W-1:0] src_b;
      logic [XO_W-1:0]   xo;
   } vq_instr_t;

endpackage

// File: rtl/vqsr_decode.sv
module vqsr_decode
   import vqsr_pkg::*;
#(
   parameter int unsigned PRI_OPC  = 4,
   parameter int unsigned XO_BITS  = 708,
   parameter int unsigned XO_BYTES = 1100
) (
   input  vq_instr_t instr,
   output vq_op_e    op
);

   localparam logic [PRI_W-1:0] PRI_K   = PRI_W'(PRI_OPC);
   localparam logic [XO_W-1:0]  XO_BIT_K = XO_W'(XO_BITS);
   localparam logic [XO_W-1:0]  XO_BYT_K = XO_W'(XO_BYTES);

   logic pri_hit;
   logic unused_regf;

   assign pri_hit     = (instr.pri == PRI_K);
   assign unused_regf = ^{instr.dst, instr.src_a, instr.src_b};

   always_comb begin
      op = VQ_OP_NONE;
      if (pri_hit) begin
         if (instr.xo == XO_BIT_K)
            op = VQ_OP_BITS;
         else if (instr.xo == XO_BYT_K)
            op = VQ_OP_BYTES;
      end
   end

endmodule

// File: rtl/vqsr_count.sv
module vqsr_count
   import vqsr_pkg::*;
#(
   parameter  int unsigned DATA_W = 128,
   localparam int unsigned LANES  = DATA_W / LANE_W,
   localparam int unsigned BYTE_W = $clog2(LANES),
   localparam int unsigned SH_W   = BIT_W + BYTE_W
) (
   input  logic [DATA_W-1:0] opnd_b,
   input  vq_op_e            op,
   output logic [SH_W-1:0]   amt,
   output logic              mismatch
);

   logic [BIT_W-1:0]  bit_amt;
   logic [BYTE_W-1:0] byte_amt;
   logic [LANES-1:0]  lane_eq;
   logic [LANES-1:0]  lane_hi;
   logic              unused_hi;

   assign bit_amt  = opnd_b[BIT_W-1:0];
   assign byte_amt = opnd_b[BIT_W +: BYTE_W];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_eq[k] = (opnd_b[k*LANE_W +: BIT_W] == bit_amt);
      assign lane_hi[k] = ^opnd_b[k*LANE_W+BIT_W +: (LANE_W-BIT_W)];
   end

   assign unused_hi = ^lane_hi;

   always_comb begin
      amt      = '0;
      mismatch = 1'b0;
      unique case (op)
         VQ_OP_BITS: begin
            amt      = SH_W'(bit_amt);
            mismatch = ~(&lane_eq);
         end
         VQ_OP_BYTES: begin
            amt = {byte_amt, {BIT_W{1'b0}}};
         end
         default: begin
            amt      = '0;
            mismatch = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/vqsr_shifter.sv
module vqsr_shifter #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned SH_W   = 7,
   parameter int unsigned STYLE  = 0
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] dout
);

   if (STYLE == 0) begin : g_stages
      logic [DATA_W-1:0] stg [0:SH_W];
      assign stg[0] = din;
      for (genvar s = 0; s < SH_W; s++) begin : g_stg
         localparam int unsigned STEP = 1 << s;
         assign stg[s+1] = amt[s] ? (stg[s] >> STEP) : stg[s];
      end
      assign dout = stg[SH_W];
   end else begin : g_direct
      assign dout = din >> amt;
   end

endmodule

// File: rtl/vqsr_unit.sv
module vqsr_unit
   import vqsr_pkg::*;
#(
   parameter int unsigned DATA_W   = 128,
   parameter int unsigned REG_OUT  = 1,
   parameter int unsigned STYLE    = 0,
   parameter int unsigned PRI_OPC  = 4,
   parameter int unsigned XO_BITS  = 708,
   parameter int unsigned XO_BYTES = 1100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] res_data,
   output logic              res_valid,
   output logic              res_undef
);

   localparam int unsigned LANES  = DATA_W / LANE_W;
   localparam int unsigned BYTE_W = $clog2(LANES);
   localparam int unsigned SH_W   = BIT_W + BYTE_W;

   initial begin
      assert (DATA_W % LANE_W == 0) else $error("DATA_W must be whole bytes");
      assert (LANES >= 2 && (1 << BYTE_W) == LANES) else $error("byte count must be a power of two");
      assert (REG_OUT <= 1) else $error("REG_OUT must be 0 or 1");
      assert (STYLE <= 1) else $error("STYLE must be 0 or 1");
      assert (PRI_OPC < (1 << PRI_W)) else $error("PRI_OPC too wide");
      assert (XO_BITS < (1 << XO_W) && XO_BYTES < (1 << XO_W)) else $error("extended opcode too wide");
      assert (XO_BITS != XO_BYTES) else $error("extended opcodes must differ");
   end

   vq_instr_t         ins_s;
   vq_op_e            op;
   logic [SH_W-1:0]   amt;
   logic              mismatch;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] nxt_data;
   logic              nxt_valid;
   logic              nxt_undef;

   assign ins_s = vq_instr_t'(instr);

   vqsr_decode #(
      .PRI_OPC  (PRI_OPC),
      .XO_BITS  (XO_BITS),
      .XO_BYTES (XO_BYTES)
   ) u_decode (
      .instr (ins_s),
      .op    (op)
   );

   vqsr_count #(
      .DATA_W (DATA_W)
   ) u_count (
      .opnd_b   (opnd_b),
      .op       (op),
      .amt      (amt),
      .mismatch (mismatch)
   );

   vqsr_shifter #(
      .DATA_W (DATA_W),
      .SH_W   (SH_W),
      .STYLE  (STYLE)
   ) u_shift (
      .din  (opnd_a),
      .amt  (amt),
      .dout (shifted)
   );

   assign nxt_valid = (op != VQ_OP_NONE);
   assign nxt_undef = mismatch;
   assign nxt_data  = nxt_valid ? shifted : '0;

   if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            res_data  <= '0;
            res_valid <= 1'b0;
            res_undef <= 1'b0;
         end else begin
            res_data  <= nxt_data;
            res_valid <= nxt_valid;
            res_undef <= nxt_undef;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign res_data   = nxt_data;
      assign res_valid  = nxt_valid;
      assign res_undef  = nxt_undef;
   end

endmodule

// File: rtl/vqsr_unit_chk.sv
module vqsr_unit_chk #(
   parameter int unsigned DATA_W   = 128,
   parameter int unsigned REG_OUT  = 1,
   parameter int unsigned PRI_OPC  = 4,
   parameter int unsigned XO_BYTES = 1100
) (
   input logic              clk,
   input logic              rst,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] res_data,
   input logic              res_valid,
   input logic              res_undef
);

   AST_UNDEF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      res_undef |-> res_valid); // R3

   AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> (res_data == '0)); // R6

   if (REG_OUT != 0) begin : g_reg_chk
      AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
         $past(rst) |-> (!res_valid && !res_undef && res_data == '0)); // R8

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
         res_valid |-> ($past(instr[31:26]) == 6'(PRI_OPC))); // R7

      AST_BYTE_NO_UNDEF: assert property (@(posedge clk) disable iff (rst)
         (res_valid && $past(instr[10:0]) == 11'(XO_BYTES)) |-> !res_undef); // R5
   end else begin : g_comb_chk
      AST_VALID_PRIMARY: assert property (@(posedge clk) disable iff (rst)
         res_valid |-> (instr[31:26] == 6'(PRI_OPC))); // R1

      AST_BYTE_NO_UNDEF: assert property (@(posedge clk) disable iff (rst)
         (res_valid && instr[10:0] == 11'(XO_BYTES)) |-> !res_undef); // R5
   end

endmodule

bind vqsr_unit vqsr_unit_chk #(
   .DATA_W   (DATA_W),
   .REG_OUT  (REG_OUT),
   .PRI_OPC  (PRI_OPC),
   .XO_BYTES (XO_BYTES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .instr     (instr),
   .res_data  (res_data),
   .res_valid (res_valid),
   .res_undef (res_undef)
);

// File: tb/vqsr_unit_bench.sv
module vqsr_unit_bench;

   typedef struct packed {
      logic         v;
      logic         u;
      logic [127:0] d;
   } exp_t;

   typedef struct {
      exp_t  e;
      string req;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [31:0]  instr = '0;
   logic [127:0] opnd_a = '0;
   logic [127:0] opnd_b = '0;

   logic [127:0] r_data, c_data;
   logic         r_valid, c_valid, r_undef, c_undef;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   item_t sb_q[$];

   always #5 clk = ~clk;

   vqsr_unit #(.REG_OUT(1), .STYLE(0)) u_vqsr_unit (
      .clk(clk), .rst(rst), .instr(instr), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .res_data(r_data), .res_valid(r_valid), .res_undef(r_undef));

   vqsr_unit #(.REG_OUT(0), .STYLE(1)) u_vqsr_comb (
      .clk(clk), .rst(rst), .instr(instr), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .res_data(c_data), .res_valid(c_valid), .res_undef(c_undef));

   function automatic logic [31:0] mk_ins(int pri, int rt, int ra, int rb, int xo);
      return {6'(pri), 5'(rt), 5'(ra), 5'(rb), 11'(xo)};
   endfunction

   // Expected outputs derived from R1..R6 and R9
   function automatic exp_t model(logic [31:0] ins, logic [127:0] a, logic [127:0] b);
      exp_t e;
      e = '0;
      if (ins[31:26] == 6'd4 && ins[10:0] == 11'd708) begin
         e.v = 1'b1;
         e.d = a >> b[2:0];
         for (int k = 0; k < 16; k++)
            if (b[8*k +: 3] != b[2:0]) e.u = 1'b1;
      end else if (ins[31:26] == 6'd4 && ins[10:0] == 11'd1100) begin
         e.v = 1'b1;
         e.d = a >> (8 * int'(b[6:3]));
      end
      return e;
   endfunction

   // count operand whose every byte repeats amt; upper bits vary per byte
   function automatic logic [127:0] mk_b_same(int amt, int seed);
      logic [127:0] b;
      for (int k = 0; k < 16; k++)
         b[8*k +: 8] = {5'(seed * 7 + k * 3), 3'(amt)};
      return b;
   endfunction

   function automatic logic [127:0] mk_a(int i);
      logic [31:0] w;
      w = 32'hC3A5_96F1 ^ (32'(i) * 32'h9E37_79B9);
      return {w, ~w, {w[15:0], w[31:16]}, w ^ 32'h0F0F_F0F0};
   endfunction

   task automatic cmp(string who, string req, exp_t got, exp_t exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got v=%0b u=%0b d=%h exp v=%0b u=%0b d=%h",
                  who, req, got.v, got.u, got.d, exp.v, exp.u, exp.d);
      end
   endtask

   // driver: push expected item for the registered copy, check the combinational copy now
   task automatic drive(logic [31:0] ins, logic [127:0] a, logic [127:0] b, string req);
      item_t it;
      @(negedge clk);
      instr  = ins;
      opnd_a = a;
      opnd_b = b;
      it.e   = model(ins, a, b);
      it.req = req;
      sb_q.push_back(it);
      #1;
      cmp("comb", {req, " R7"}, '{c_valid, c_undef, c_data}, it.e);
   endtask

   // monitor: registered copy shows the previous edge's inputs
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         cmp("reg", {it.req, " R7"}, '{r_valid, r_undef, r_data}, it.e);
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         finish_run();
      end
   end

   initial begin
      logic [127:0] b;
      // reset with a recognized op applied: R8
      instr  = mk_ins(4, 1, 2, 3, 708);
      opnd_a = mk_a(0);
      opnd_b = mk_b_same(1, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      cmp("reg", "R8", '{r_valid, r_undef, r_data}, '0);
      rst = 1'b0;

      // R1 R2: bit shift with consistent count bytes, every amount
      for (int s = 0; s < 8; s++)
         drive(mk_ins(4, 0, 0, 0, 708), mk_a(s + 1), mk_b_same(s, s), "R1 R2");
      drive(mk_ins(4, 0, 0, 0, 708), {128{1'b1}}, mk_b_same(7, 3), "R2");

      // R3: one disagreeing byte at the top, middle, and lane 1
      b = mk_b_same(5, 2); b[122:120] = 3'd4;
      drive(mk_ins(4, 0, 0, 0, 708), mk_a(20), b, "R3");
      b = mk_b_same(3, 4); b[58:56] = 3'd0;
      drive(mk_ins(4, 0, 0, 0, 708), mk_a(21), b, "R3");
      b = mk_b_same(0, 5); b[10:8] = 3'd7;
      drive(mk_ins(4, 0, 0, 0, 708), mk_a(22), b, "R3");

      // R4: byte shift, every count
      for (int n = 0; n < 16; n++) begin
         b = mk_a(n + 40);
         b[6:3] = 4'(n);
         drive(mk_ins(4, 0, 0, 0, 1100), mk_a(n + 30), b, "R4");
      end

      // R5: same count, other bits all ones versus all zeros, and count bytes disagreeing
      b = '0; b[6:3] = 4'd9;
      drive(mk_ins(4, 0, 0, 0, 1100), mk_a(50), b, "R5");
      b = '1; b[6:3] = 4'd9;
      drive(mk_ins(4, 0, 0, 0, 1100), mk_a(50), b, "R5");
      b = mk_b_same(2, 1); b[6:3] = 4'd15; b[66:64] = 3'd6;
      drive(mk_ins(4, 0, 0, 0, 1100), {128{1'b1}}, b, "R5");

      // R6: unknown primary or extended opcodes
      drive(mk_ins(5, 0, 0, 0, 708), mk_a(60), mk_b_same(2, 0), "R6");
      drive(mk_ins(0, 0, 0, 0, 1100), mk_a(61), mk_b_same(2, 0), "R6");
      drive(mk_ins(4, 0, 0, 0, 709), mk_a(62), mk_b_same(2, 0), "R6");
      drive(mk_ins(4, 0, 0, 0, 1100 ^ 1024), mk_a(63), mk_b_same(2, 0), "R6");
      drive(mk_ins(4, 0, 0, 0, 0), mk_a(64), '1, "R6");
      drive(mk_ins(36, 0, 0, 0, 708), mk_a(65), mk_b_same(1, 0), "R6");

      // R9: register-number fields take arbitrary values
      drive(mk_ins(4, 31, 0, 17, 708), mk_a(70), mk_b_same(6, 9), "R9");
      drive(mk_ins(4, 5, 31, 31, 1100), mk_a(71), mk_b_same(6, 9), "R9");
      drive(mk_ins(4, 31, 31, 31, 708), mk_a(72), mk_b_same(4, 1), "R9");

      repeat (3) @(negedge clk);

      // reset raised while a recognized op is applied: R8
      instr  = mk_ins(4, 0, 0, 0, 1100);
      opnd_a = mk_a(80);
      opnd_b = {120'd0, 8'h08};
      rst    = 1'b1;
      @(negedge clk);
      cmp("reg", "R8", '{r_valid, r_undef, r_data}, '0);
      rst = 1'b0;
      @(negedge clk);

      done = 1'b1;
      finish_run();
   end

endmodule